// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo audio from an external master over a three-wire serial link. The three wires are a bit clock, a frame sync and a data line. The block never drives the bit clock or the frame sync. All three inputs are sampled by a faster system clock through synchronizer stages. The block detects the chosen bit-clock edge in the system domain and takes one data bit on each such edge. A mode input selects one of three framings:

- I2S-style, where the MSB is delayed one bit after the sync edge.
- Left-justified, where the MSB arrives with the sync edge.
- DSP pulse mode, where a one-bit-wide sync pulse starts a frame. In this mode the left and right words follow back-to-back, and a zero- or one-bit extra delay can be selected.

When a word of the programmed length is complete, the block places it left-aligned in a 24-bit output with zeros in the low bits. It pulses a valid strobe for one system-clock cycle and tags the word as left or right. If a sync event cuts a word short, the partial word is discarded and a sticky error flag is raised. Software clears that flag with a one-cycle clear pulse. A zero sample-rate setting holds the receiver idle.

A state machine handles the framing. It has four states:

- IDLE: the receiver is disabled or waiting for the first sync event.
- SKIP: the receiver is counting delay bits before the MSB.
- SHIFT: the receiver is taking word bits.
- WAIT: the word is complete and any further bits are ignored.

It has five named transitions:

- *sync* moves from any state to SKIP, or to SHIFT.
- *skip_done* moves from SKIP to SHIFT.
- *word_done* moves from SHIFT to WAIT. In DSP mode, after the left word, it moves from SHIFT back to SHIFT for the right word.
- *short* is a sync event seen in SKIP or SHIFT. It sets the error flag and then behaves as *sync*.
- *disable* moves from any state to IDLE.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rate_i` is 0 or `fmt_i` is 3 (reserved), no valid strobe is produced and the framing state returns to IDLE. After re-enabling, the first active edge only records the sync level.
- R2: With `fmt_i`=0 (I2S-style), a word starts on a change of the sync level seen at an active edge. The MSB is taken on the next active edge. Sync low marks a left word and sync high marks a right word.
- R3: With `fmt_i`=1 (left-justified), the MSB is taken on the same active edge that first sees the changed sync level. Sync high marks a left word and sync low marks a right word.
- R4: With `fmt_i`=2 (DSP), an active edge that sees sync high starts a frame. The left MSB is taken on the next active edge when `dsp_late_i`=0, or one edge later when it is 1. The right word follows the left LSB immediately.
- R5: `wlen_i` selects the word length: 0 gives 8 bits, 1 gives 16, 2 gives 20 and 3 gives 24. Bits arrive MSB first.
- R6: Each completed word appears on `smp_data_o` with its MSB at bit 23 and zeros below its LSB. `smp_valid_o` is high for exactly one cycle, and `smp_right_o` is 1 for a right word.
- R7: Data bits after a word's LSB and before the next sync event do not affect any output.
- R8: With `bclk_inv_i`=1, falling bit-clock edges are the active edges. With `bclk_inv_i`=0, rising edges are the active edges.
- R9: A sync event seen before the current word completes discards that word without a strobe and sets `short_err_o`. The flag stays set until a cycle with `err_clr_i`=1; if a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock from the master |
| fsync_i | input | 1 | Frame sync from the master |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 I2S-style, 1 left-justified, 2 DSP, 3 reserved |
| wlen_i | input | 2 | Word length code (8/16/20/24 bits) |
| bclk_inv_i | input | 1 | Use falling bit-clock edges when 1 |
| dsp_late_i | input | 1 | DSP mode: one extra bit of delay before the left MSB |
| rate_i | input | RATE_W | Sample-rate setting; zero disables the receiver |
| err_clr_i | input | 1 | Clears the short-frame flag |
| smp_data_o | output | 24 | Received word, left-aligned |
| smp_valid_o | output | 1 | One-cycle strobe for a new word |
| smp_right_o | output | 1 | Channel of the strobed word (1 = right) |
| short_err_o | output | 1 | Sticky short-frame error flag |

## Verification
The hardest case to reach from the ports is a sync event that arrives part-way through a word. A correct master never produces one, so the bench plays the master itself. It cuts a left-justified left slot after ten bits, and then sends a full right slot. The bench then checks four things:

- only the right word is strobed;
- the error flag is set;
- the flag survives further traffic;
- the flag drops only after the clear pulse.

Ignored trailing bits are made visible by filling every padding slot with ones. With this fill, any leak into the output shows up as a mismatch in the low bits or in the padding zeros.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAR_OUT_W = 24;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_DSP  = 2'd2,
        FMT_RSVD = 2'd3
    } sar_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_WAIT  = 2'd3
    } sar_state_e;

    function automatic logic [4:0] sar_wlen_bits(input logic [1:0] code);
        logic [4:0] n;
        unique case (code)
            2'd0:    n = 5'd8;
            2'd1:    n = 5'd16;
            2'd2:    n = 5'd20;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    input  logic sdata_i,
    input  logic inv_i,
    output logic act_edge_o,
    output logic fs_o,
    output logic sd_o
);

    logic [STAGES-1:0] bclk_sh;
    logic [STAGES-1:0] fs_sh;
    logic [STAGES-1:0] sd_sh;
    logic              bclk_last;

    // Data and sync go through the same depth as the clock so all three stay aligned.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_sh   <= '0;
            fs_sh     <= '0;
            sd_sh     <= '0;
            bclk_last <= 1'b0;
        end else begin
            bclk_sh   <= {bclk_sh[STAGES-2:0], bclk_i};
            fs_sh     <= {fs_sh[STAGES-2:0], fsync_i};
            sd_sh     <= {sd_sh[STAGES-2:0], sdata_i};
            bclk_last <= bclk_sh[STAGES-1];
        end
    end

    logic rise_c;
    logic fall_c;
    assign rise_c     = bclk_sh[STAGES-1] & ~bclk_last;
    assign fall_c     = ~bclk_sh[STAGES-1] & bclk_last;
    assign act_edge_o = inv_i ? fall_c : rise_c;
    assign fs_o       = fs_sh[STAGES-1];
    assign sd_o       = sd_sh[STAGES-1];

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [1:0]           fmt_i,
    input  logic [1:0]           wlen_i,
    input  logic                 dsp_late_i,
    input  logic                 act_edge_i,
    input  logic                 fs_i,
    input  logic                 sd_i,
    input  logic                 err_clr_i,
    output logic [SAR_OUT_W-1:0] data_o,
    output logic                 valid_o,
    output logic                 right_o,
    output logic                 err_o
);

    sar_state_e state_q, state_n;
    logic                 armed_q, fs_prev_q;
    logic                 skip_q, skip_n;
    logic [4:0]           cnt_q, cnt_n;
    logic [SAR_OUT_W-1:0] sh_q, sh_n;
    logic                 ch_q, ch_n;
    logic                 emit_c, err_set_c;
    logic [SAR_OUT_W-1:0] word_c, aligned_c;
    logic                 event_c, ch_evt_c;
    logic [1:0]           delay_c;
    logic [4:0]           wbits_c;

    assign wbits_c   = sar_wlen_bits(wlen_i);
    assign word_c    = {sh_q[SAR_OUT_W-2:0], sd_i};
    assign aligned_c = word_c << (5'd24 - wbits_c);

    // Sync event and per-format delay to the MSB edge.
    always_comb begin
        event_c  = 1'b0;
        delay_c  = 2'd1;
        ch_evt_c = 1'b0;
        unique case (fmt_i)
            FMT_I2S: begin
                event_c  = act_edge_i & armed_q & (fs_i != fs_prev_q);
                delay_c  = 2'd1;
                ch_evt_c = fs_i;
            end
            FMT_LJ: begin
                event_c  = act_edge_i & armed_q & (fs_i != fs_prev_q);
                delay_c  = 2'd0;
                ch_evt_c = ~fs_i;
            end
            FMT_DSP: begin
                event_c  = act_edge_i & armed_q & fs_i;
                delay_c  = dsp_late_i ? 2'd2 : 2'd1;
                ch_evt_c = 1'b0;
            end
            default: begin
                event_c  = 1'b0;
                delay_c  = 2'd1;
                ch_evt_c = 1'b0;
            end
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_n   = state_q;
        skip_n    = skip_q;
        cnt_n     = cnt_q;
        sh_n      = sh_q;
        ch_n      = ch_q;
        emit_c    = 1'b0;
        err_set_c = 1'b0;
        if (!en_i) begin
            state_n = ST_IDLE;                         // disable
        end else if (event_c) begin
            err_set_c = (state_q == ST_SKIP) || (state_q == ST_SHIFT);  // short
            ch_n      = ch_evt_c;
            cnt_n     = 5'd0;
            sh_n      = '0;
            unique case (delay_c)
                2'd0: begin
                    state_n = ST_SHIFT;
                    sh_n    = {{(SAR_OUT_W-1){1'b0}}, sd_i};
                    cnt_n   = 5'd1;
                end
                2'd1:    state_n = ST_SHIFT;
                default: begin
                    state_n = ST_SKIP;
                    skip_n  = 1'b1;
                end
            endcase
        end else if (act_edge_i) begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_SKIP: begin
                    skip_n = 1'b0;
                    if (skip_q) state_n = ST_SHIFT;        // skip_done
                end
                ST_SHIFT: begin
                    sh_n  = word_c;
                    cnt_n = cnt_q + 5'd1;
                    if (cnt_q + 5'd1 == wbits_c) begin     // word_done
                        emit_c = 1'b1;
                        cnt_n  = 5'd0;
                        sh_n   = '0;
                        if (fmt_i == FMT_DSP && !ch_q) begin
                            ch_n    = 1'b1;
                            state_n = ST_SHIFT;
                        end else begin
                            state_n = ST_WAIT;
                        end
                    end
                end
                ST_WAIT: state_n = ST_WAIT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            skip_q    <= 1'b0;
            cnt_q     <= 5'd0;
            sh_q      <= '0;
            ch_q      <= 1'b0;
            armed_q   <= 1'b0;
            fs_prev_q <= 1'b0;
        end else begin
            state_q <= state_n;
            skip_q  <= skip_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            ch_q    <= ch_n;
            if (!en_i) begin
                armed_q <= 1'b0;
            end else if (act_edge_i) begin
                armed_q   <= 1'b1;
                fs_prev_q <= fs_i;
            end
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            right_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= emit_c;
            if (emit_c) begin
                data_o  <= aligned_c;
                right_o <= ch_q;
            end
            if (err_set_c)      err_o <= 1'b1;
            else if (err_clr_i) err_o <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RATE_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_i,
    input  logic                 fsync_i,
    input  logic                 sdata_i,
    input  logic [1:0]           fmt_i,
    input  logic [1:0]           wlen_i,
    input  logic                 bclk_inv_i,
    input  logic                 dsp_late_i,
    input  logic [RATE_W-1:0]    rate_i,
    input  logic                 err_clr_i,
    output logic [SAR_OUT_W-1:0] smp_data_o,
    output logic                 smp_valid_o,
    output logic                 smp_right_o,
    output logic                 short_err_o
);

    logic act_edge_w, fs_w, sd_w, en_w;

    assign en_w = (rate_i != '0) && (fmt_i != FMT_RSVD);

    sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fsync_i   (fsync_i),
        .sdata_i   (sdata_i),
        .inv_i     (bclk_inv_i),
        .act_edge_o(act_edge_w),
        .fs_o      (fs_w),
        .sd_o      (sd_w)
    );

    sar_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .fmt_i     (fmt_i),
        .wlen_i    (wlen_i),
        .dsp_late_i(dsp_late_i),
        .act_edge_i(act_edge_w),
        .fs_i      (fs_w),
        .sd_i      (sd_w),
        .err_clr_i (err_clr_i),
        .data_o    (smp_data_o),
        .valid_o   (smp_valid_o),
        .right_o   (smp_right_o),
        .err_o     (short_err_o)
    );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int RATE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        fmt_i,
    input logic [1:0]        wlen_i,
    input logic [RATE_W-1:0] rate_i,
    input logic              err_clr_i,
    input logic [23:0]       smp_data_o,
    input logic              smp_valid_o,
    input logic              short_err_o
);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o);

    assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == '0 || fmt_i == 2'd3) |=> !smp_valid_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (short_err_o && !err_clr_i) |=> short_err_o);

    assert_pad8_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && wlen_i == 2'd0 && $stable(wlen_i)) |-> (smp_data_o[15:0] == 16'd0));

    assert_pad20_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && wlen_i == 2'd2 && $stable(wlen_i)) |-> (smp_data_o[3:0] == 4'd0));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.RATE_W(RATE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_i      (fmt_i),
    .wlen_i     (wlen_i),
    .rate_i     (rate_i),
    .err_clr_i  (err_clr_i),
    .smp_data_o (smp_data_o),
    .smp_valid_o(smp_valid_o),
    .short_err_o(short_err_o)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, bclk, fsync, sdata, inv, late, clr;
    logic [1:0]  fmt, wlen, rate;
    logic [23:0] smp_data;
    logic        smp_valid, smp_right, short_err;

    serial_audio_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
        .fmt_i(fmt), .wlen_i(wlen), .bclk_inv_i(inv), .dsp_late_i(late), .rate_i(rate),
        .err_clr_i(clr), .smp_data_o(smp_data), .smp_valid_o(smp_valid),
        .smp_right_o(smp_right), .short_err_o(short_err)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    int          n_valid  = 0;
    logic [24:0] exp_q[$];
    logic [24:0] mon_e;
    string       cur_req  = "R6";

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, expv);
        end
    endtask

    // Monitor: every strobe is compared with the next expected {right, data}.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            n_valid++;
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL %s unexpected sample got=%h expected=none", cur_req, smp_data);
            end else begin
                mon_e = exp_q.pop_front();
                chk(cur_req, {7'd0, smp_right, smp_data}, {7'd0, mon_e});
            end
        end
    end

    function automatic int wb_of(input logic [1:0] w);
        case (w)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] mkval(input int c, input int f, input int ch, input int wb);
        logic [31:0] h;
        h = (c * 32'h9E3779B1) ^ ((f + 1) * 32'h85EBCA6B) ^ (ch != 0 ? 32'hC2B2AE35 : 32'h1B873593);
        return h[23:0] & (24'hFFFFFF << (24 - wb));
    endfunction

    // One bit period: drive at the inactive transition, then the active edge (R8).
    task automatic drive_bit(input logic fs, input logic d);
        bclk  = inv;
        fsync = fs;
        sdata = d;
        repeat (4) @(negedge clk);
        bclk = ~inv;
        repeat (4) @(negedge clk);
    endtask

    // Slot data: word bits between positions st and st+wb-1, ones elsewhere (R7).
    function automatic logic slot_bit(input logic [23:0] v, input int i, input int st, input int wb);
        if (i >= st && i < st + wb) return v[23 - (i - st)];
        return 1'b1;
    endfunction

    task automatic run_cfg(input int c, input int fm, input int wl, input int iv, input int lt);
        int          wb;
        logic [23:0] lv, rv;
        logic        pre_fs, tail_fs;
        rate = 2'd0;
        repeat (2) @(negedge clk);
        fmt  = fm[1:0];
        wlen = wl[1:0];
        inv  = iv[0];
        late = lt[0];
        bclk = inv;
        wb   = wb_of(wlen);
        if (fm == 0)      cur_req = (iv != 0) ? "R2/R5/R8" : "R2/R5";
        else if (fm == 1) cur_req = (iv != 0) ? "R3/R5/R8" : "R3/R5";
        else              cur_req = (iv != 0) ? "R4/R5/R8" : "R4/R5";
        pre_fs  = (fm == 0) ? 1'b1 : 1'b0;
        tail_fs = (fm == 0) ? 1'b1 : 1'b0;
        rate = 2'd1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) drive_bit(pre_fs, 1'b1);
        for (int f = 0; f < 2; f++) begin
            lv = mkval(c, f, 0, wb);
            rv = mkval(c, f, 1, wb);
            exp_q.push_back({1'b0, lv});
            exp_q.push_back({1'b1, rv});
            if (fm == 0) begin
                for (int i = 0; i < 32; i++) drive_bit(1'b0, slot_bit(lv, i, 1, wb));
                for (int i = 0; i < 32; i++) drive_bit(1'b1, slot_bit(rv, i, 1, wb));
            end else if (fm == 1) begin
                for (int i = 0; i < 32; i++) drive_bit(1'b1, slot_bit(lv, i, 0, wb));
                for (int i = 0; i < 32; i++) drive_bit(1'b0, slot_bit(rv, i, 0, wb));
            end else begin
                for (int i = 0; i < 64; i++) begin
                    int st;
                    st = (lt != 0) ? 2 : 1;
                    if (i >= st + wb) drive_bit(i == 0, slot_bit(rv, i, st + wb, wb));
                    else              drive_bit(i == 0, slot_bit(lv, i, st, wb));
                end
            end
        end
        for (int k = 0; k < 4; k++) drive_bit(tail_fs, 1'b1);
        repeat (20) @(negedge clk);
        chk("R6 all words strobed", exp_q.size(), 0);
        exp_q.delete();
        chk("R9 no false error", short_err, 1'b0);
        rate = 2'd0;
    endtask

    int base;
    int cfg;

    initial begin
        rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sdata = 1'b0;
        inv = 1'b0; late = 1'b0; clr = 1'b0; fmt = 2'd1; wlen = 2'd3; rate = 2'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset valid", smp_valid, 1'b0);
        chk("R6 reset data", smp_data, 24'd0);
        chk("R9 reset err", short_err, 1'b0);

        // Sweep of format, word length, edge polarity and DSP delay.
        cfg = 0;
        for (int fm = 0; fm < 3; fm++)
            for (int wl = 0; wl < 4; wl++)
                for (int iv = 0; iv < 2; iv++)
                    for (int lt = 0; lt < ((fm == 2) ? 2 : 1); lt++) begin
                        run_cfg(cfg, fm, wl, iv, lt);
                        cfg++;
                    end

        // R1: disabled by rate 0, then by reserved format.
        cur_req = "R1";
        fmt = 2'd1; wlen = 2'd0; inv = 1'b0; rate = 2'd0;
        base = n_valid;
        for (int k = 0; k < 4; k++) drive_bit(1'b0, 1'b1);
        for (int i = 0; i < 32; i++) drive_bit(1'b1, i[0]);
        for (int i = 0; i < 32; i++) drive_bit(1'b0, i[1]);
        repeat (20) @(negedge clk);
        chk("R1 rate zero silent", n_valid - base, 0);
        fmt = 2'd3; rate = 2'd2;
        for (int i = 0; i < 32; i++) drive_bit(1'b1, i[0]);
        for (int i = 0; i < 32; i++) drive_bit(1'b0, i[1]);
        repeat (20) @(negedge clk);
        chk("R1 reserved format silent", n_valid - base, 0);
        chk("R1 no error while off", short_err, 1'b0);
        rate = 2'd0;
        repeat (2) @(negedge clk);

        // R9: short left-justified word, then a full right word.
        cur_req = "R9";
        fmt = 2'd1; wlen = 2'd3; inv = 1'b0; bclk = 1'b0; rate = 2'd1;
        repeat (4) @(negedge clk);
        base = n_valid;
        for (int k = 0; k < 4; k++) drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) drive_bit(1'b1, 1'b1);
        exp_q.push_back({1'b1, 24'hA5C3F1});
        for (int i = 0; i < 32; i++) drive_bit(1'b0, slot_bit(24'hA5C3F1, i, 0, 24));
        repeat (20) @(negedge clk);
        chk("R9 only full word strobed", n_valid - base, 1);
        chk("R9 queue drained", exp_q.size(), 0);
        chk("R9 error set", short_err, 1'b1);
        for (int k = 0; k < 6; k++) drive_bit(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk("R9 error sticky", short_err, 1'b1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 error cleared", short_err, 1'b0);
        rate = 2'd0;
        exp_q.delete();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule